// File: doc/BRIEF.md
# Serial EEPROM Slave with Block Protection

This block is a mode-0 SPI slave (clock idles low, data sampled on the rising SCK edge, shifted out on the falling edge) that stands in for a 512-byte non-volatile byte array. The host runs it through six commands: set the write-enable latch, clear it, read the status byte, write the status byte, read data, and write data. A data read streams bytes from any start address. A data write buffers up to 16 bytes inside one 16-byte page. The array is updated only when chip select goes high.

Every write needs the write-enable latch to be set first. The write-protect pin can also block it, and so can the two protect bits in the status byte. These bits shield nothing, the upper quarter, the upper half or the whole array. After each accepted write, a busy flag stays high for a parameterised number of system clocks to model the internal programming time. While that flag is high, only the status read is served.

The SPI pins are sampled into the system clock domain. A byte shifter module assembles incoming bytes and drives MISO. The top module runs the command state machine with these states: ST_OPC waits for the opcode, ST_ADDR takes the low address byte, ST_RDAT streams read data, ST_WDAT fills the page buffer, ST_STAT streams the status byte, ST_WSR takes the status value, and ST_SKIP discards bytes until the frame ends. The transitions are as follows. ST_OPC goes to ST_ADDR on a read or write opcode, to ST_STAT on a status read, and to ST_WSR on a status write. ST_OPC goes to ST_SKIP on a latch command, on an unknown opcode, or on any opcode other than a status read while busy. ST_ADDR goes to ST_RDAT for a read and to ST_WDAT for a write. ST_WSR goes to ST_SKIP after its byte. Every state returns to ST_OPC when chip select goes high. A separate counter module provides the busy window.

Top module: `eep_top`

## Requirements
- R1: After reset the status byte reads 0x00 and every array byte reads 0xFF.
- R2: Opcode 0x06 sets the write-enable latch, which shows as status bit 1. Opcode 0x04 clears it.
- R3: A data write (opcode 0x02) sent while the latch is clear leaves the array unchanged and does not start a busy window.
- R4: The read opcode is 0x03 with address bit 8 carried in opcode bit 3, so 0x0B selects the upper half. The next byte is address bits 7:0. Data then streams from that address, incrementing and wrapping from 0x1FF to 0x000.
- R5: The write opcode is 0x02, with address bit 8 in opcode bit 3. Each data byte goes to the next location within the same 16-byte page, wrapping from the page's last byte to its first. Nothing outside the page changes. The array is updated when chip select goes high.
- R6: An accepted write or status write sets status bit 0 for WR_CYCLES clocks. While that bit is set, every opcode except status read (0x05) is ignored, including reads, which return 0x00 on MISO.
- R7: The write-enable latch clears when the busy window of an accepted write ends.
- R8: Status bits 3:2 select write protection: 00 none, 01 addresses 0x180-0x1FF, 10 addresses 0x100-0x1FF, 11 the whole array. A write into a protected page is dropped. The status write (opcode 0x01) sets these bits.
- R9: While wp_n is low, neither data writes nor status writes take effect.
- R10: A status read returns the current status byte on every byte clocked out until chip select goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all SPI pins are sampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, mode 0 |
| mosi | input | 1 | Serial data from the host |
| wp_n | input | 1 | Write-protect pin, active low |
| miso | output | 1 | Serial data to the host |

## Verification
The bench builds the block with WR_CYCLES set to 1000 clocks in place of the default 5000. That makes the busy window longer than one whole status-read frame and one read frame, so the bench can see status bit 0 set right after a commit and can show that a read issued during the window returns zeros. ADDR_W and PAGE_BYTES keep their defaults of 9 and 16. With those values the array wraps at 0x1FF, opcode bit 3 acts as the ninth address bit, and the quarter and half protect boundaries fall at 0x180 and 0x100.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_ADDR,
        ST_RDAT,
        ST_WDAT,
        ST_STAT,
        ST_WSR,
        ST_SKIP
    } eep_state_t;

    localparam logic [7:0] CMD_LATCH_SET = 8'h06;
    localparam logic [7:0] CMD_LATCH_CLR = 8'h04;
    localparam logic [7:0] CMD_STAT_RD   = 8'h05;
    localparam logic [7:0] CMD_STAT_WR   = 8'h01;

    // hi2 = two most significant address bits of the target
    function automatic logic region_locked(input logic [1:0] prot, input logic [1:0] hi2);
        unique case (prot)
            2'b00: region_locked = 1'b0;
            2'b01: region_locked = (hi2 == 2'b11);
            2'b10: region_locked = hi2[1];
            2'b11: region_locked = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/eep_spi_shift.sv
module eep_spi_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    input  logic       load,
    input  logic [7:0] load_byte,
    output logic [7:0] rx_byte,
    output logic       byte_done,
    output logic       cs_rise,
    output logic       cs_idle,
    output logic       miso
);
    logic       sck_s, sck_p, cs_s, cs_p, mosi_s;
    logic [2:0] bitcnt;
    logic [6:0] sh;
    logic [7:0] tx;
    logic       rise, fall;

    assign rise    = sck_s & ~sck_p;
    assign fall    = ~sck_s & sck_p;
    assign cs_rise = cs_s & ~cs_p;
    assign cs_idle = cs_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_s <= 1'b0; sck_p <= 1'b0;
            cs_s  <= 1'b1; cs_p  <= 1'b1;
            mosi_s <= 1'b0;
            bitcnt <= '0; sh <= '0; tx <= '0;
            rx_byte <= '0; byte_done <= 1'b0; miso <= 1'b0;
        end else begin
            sck_s  <= sck;
            sck_p  <= sck_s;
            cs_s   <= cs_n;
            cs_p   <= cs_s;
            mosi_s <= mosi;
            byte_done <= 1'b0;
            if (cs_s) begin
                bitcnt <= '0;
                tx     <= '0;
                miso   <= 1'b0;
            end else begin
                if (load) tx <= load_byte;
                if (rise) begin
                    sh     <= {sh[5:0], mosi_s};
                    bitcnt <= bitcnt + 3'd1;
                    if (bitcnt == 3'd7) begin
                        byte_done <= 1'b1;
                        rx_byte   <= {sh, mosi_s};
                    end
                end
                if (fall) miso <= tx[3'd7 - bitcnt];
            end
        end
    end
endmodule

// File: rtl/eep_busy.sv
module eep_busy #(
    parameter int CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt;

    assign done = busy && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= CW'(CYCLES - 1);
        end else if (done) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/eep_top.sv
module eep_top #(
    parameter int ADDR_W     = 9,
    parameter int PAGE_BYTES = 16,
    parameter int WR_CYCLES  = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    input  logic wp_n,
    output logic miso
);
    import eep_pkg::*;

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PIDX_W = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - PIDX_W;

    eep_state_t st, st_n;

    logic [7:0]        rx_byte, tx_byte;
    logic              byte_done, cs_rise, cs_idle, tx_load;
    logic              busy, busy_done, commit, wr_ok, sr_ok;
    logic              wel_q, is_wr, hi_bit, sr_got;
    logic [1:0]        bp_q;
    logic [7:0]        sr_val;
    logic [ADDR_W-1:0] addr_q, addr_in;
    logic [PAGE_W-1:0] page_q;
    logic [PIDX_W-1:0] pidx;
    logic [PAGE_BYTES-1:0] pmask;
    logic [7:0]        pbuf [PAGE_BYTES];
    logic [7:0]        mem  [DEPTH];
    logic              op_rd, op_wr;
    logic [7:0]        status;

    eep_spi_shift u_shift (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .load(tx_load), .load_byte(tx_byte), .rx_byte(rx_byte),
        .byte_done(byte_done), .cs_rise(cs_rise), .cs_idle(cs_idle), .miso(miso)
    );

    eep_busy #(.CYCLES(WR_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(commit), .busy(busy), .done(busy_done)
    );

    assign op_rd   = (rx_byte[7:4] == 4'h0) && (rx_byte[2:0] == 3'b011);
    assign op_wr   = (rx_byte[7:4] == 4'h0) && (rx_byte[2:0] == 3'b010);
    assign status  = {4'b0000, bp_q, wel_q, busy};
    assign addr_in = {hi_bit, rx_byte[ADDR_W-2:0]};

    assign wr_ok  = (st == ST_WDAT) && (|pmask) && wel_q && wp_n
                    && !region_locked(bp_q, page_q[PAGE_W-1 -: 2]);
    assign sr_ok  = sr_got && wel_q && wp_n;
    assign commit = cs_rise && (wr_ok || sr_ok);

    // next-state logic
    always_comb begin
        st_n = st;
        if (cs_idle) begin
            st_n = ST_OPC;
        end else if (byte_done) begin
            unique case (st)
                ST_OPC: begin
                    if (busy && rx_byte != CMD_STAT_RD) st_n = ST_SKIP;
                    else if (op_rd || op_wr)            st_n = ST_ADDR;
                    else if (rx_byte == CMD_STAT_RD)    st_n = ST_STAT;
                    else if (rx_byte == CMD_STAT_WR)    st_n = ST_WSR;
                    else                                st_n = ST_SKIP;
                end
                ST_ADDR: st_n = is_wr ? ST_WDAT : ST_RDAT;
                ST_WSR:  st_n = ST_SKIP;
                ST_RDAT, ST_WDAT, ST_STAT, ST_SKIP: st_n = st;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_OPC;
        else        st <= st_n;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_load <= 1'b0; tx_byte <= '0;
            wel_q <= 1'b0; bp_q <= '0; is_wr <= 1'b0; hi_bit <= 1'b0;
            sr_got <= 1'b0; sr_val <= '0;
            addr_q <= '0; page_q <= '0; pidx <= '0; pmask <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else begin
            tx_load <= 1'b0;
            if (busy_done) wel_q <= 1'b0;
            if (cs_rise) begin
                if (wr_ok)
                    for (int i = 0; i < PAGE_BYTES; i++)
                        if (pmask[i]) mem[{page_q, PIDX_W'(i)}] <= pbuf[i];
                if (sr_ok) bp_q <= sr_val[3:2];
                sr_got <= 1'b0;
                pmask  <= '0;
            end else if (byte_done && !cs_idle) begin
                unique case (st)
                    ST_OPC: begin
                        is_wr  <= op_wr;
                        hi_bit <= rx_byte[3];
                        if (!busy && rx_byte == CMD_LATCH_SET) wel_q <= 1'b1;
                        if (!busy && rx_byte == CMD_LATCH_CLR) wel_q <= 1'b0;
                        if (rx_byte == CMD_STAT_RD) begin
                            tx_byte <= status; tx_load <= 1'b1;
                        end
                    end
                    ST_ADDR: begin
                        if (is_wr) begin
                            page_q <= addr_in[ADDR_W-1:PIDX_W];
                            pidx   <= addr_in[PIDX_W-1:0];
                            pmask  <= '0;
                        end else begin
                            tx_byte <= mem[addr_in]; tx_load <= 1'b1;
                            addr_q  <= addr_in + 1'b1;
                        end
                    end
                    ST_RDAT: begin
                        tx_byte <= mem[addr_q]; tx_load <= 1'b1;
                        addr_q  <= addr_q + 1'b1;
                    end
                    ST_WDAT: begin
                        pbuf[pidx]  <= rx_byte;
                        pmask[pidx] <= 1'b1;
                        pidx        <= pidx + 1'b1;
                    end
                    ST_STAT: begin
                        tx_byte <= status; tx_load <= 1'b1;
                    end
                    ST_WSR: begin
                        sr_val <= rx_byte; sr_got <= 1'b1;
                    end
                    ST_SKIP: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/eep_chk.sv
module eep_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wp_n,
    input logic       busy,
    input logic       busy_done,
    input logic       commit,
    input logic       wel,
    input logic [1:0] bp
);
    // R6: an accepted write always opens a busy window
    p_busy_after_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> busy);
    // R6: nothing is accepted while the busy window is open
    p_no_commit_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !busy);
    // R6: the latch cannot be set while busy
    p_no_wel_rise_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !$rose(wel));
    // R7: the latch clears when the busy window ends
    p_wel_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_done |=> !wel);
    // R9: protect bits do not move while the pin is low
    p_bp_hold_wp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n |=> $stable(bp));
endmodule

bind eep_top eep_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .busy(busy),
    .busy_done(busy_done), .commit(commit), .wel(wel_q), .bp(bp_q)
);

// File: tb/sim_eep_top.sv
module sim_eep_top;
    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
    logic miso;
    int   n_run = 0, n_fail = 0;
    bit   done = 1'b0;
    logic [7:0] txb [20];
    logic [7:0] rxb [20];
    logic [7:0] shadow [512];
    logic [7:0] s;

    always #5 clk = ~clk;

    eep_top #(.ADDR_W(9), .PAGE_BYTES(16), .WR_CYCLES(1000)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .wp_n(wp_n), .miso(miso)
    );

    // {bp, addr, data, written}
    localparam logic [19:0] PROT_VEC [8] = '{
        {2'd0, 9'h1F0, 8'hC1, 1'b1},
        {2'd1, 9'h180, 8'hC2, 1'b0},
        {2'd1, 9'h17F, 8'hC3, 1'b1},
        {2'd2, 9'h100, 8'hC4, 1'b0},
        {2'd2, 9'h0FF, 8'hC5, 1'b1},
        {2'd3, 9'h000, 8'hC6, 1'b0},
        {2'd3, 9'h1FF, 8'hC7, 1'b0},
        {2'd0, 9'h180, 8'hC8, 1'b1}
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input int n);
        @(negedge clk); cs_n = 1'b0; ticks(6);
        for (int b = 0; b < n; b++) begin
            for (int i = 7; i >= 0; i--) begin
                mosi = txb[b][i];
                ticks(6);
                rxb[b][i] = miso;
                sck = 1'b1;
                ticks(6);
                sck = 1'b0;
            end
        end
        ticks(6); cs_n = 1'b1; ticks(8);
    endtask

    task automatic cmd1(input logic [7:0] op);
        txb[0] = op; frame(1);
    endtask

    task automatic rdsr(output logic [7:0] v);
        txb[0] = 8'h05; txb[1] = 8'h00; frame(2); v = rxb[1];
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        for (int k = 0; k < 40; k++) begin
            rdsr(v);
            if (v[0] == 1'b0) break;
        end
    endtask

    task automatic wrsr(input logic [7:0] v);
        txb[0] = 8'h01; txb[1] = v; frame(2);
    endtask

    task automatic write_n(input logic [8:0] a, input int n);
        txb[0] = 8'h02 | {4'b0, a[8], 3'b0}; txb[1] = a[7:0]; frame(n + 2);
    endtask

    task automatic read_n(input logic [8:0] a, input int n);
        txb[0] = 8'h03 | {4'b0, a[8], 3'b0}; txb[1] = a[7:0];
        for (int i = 2; i < n + 2; i++) txb[i] = 8'h00;
        frame(n + 2);
    endtask

    task automatic rd1(input logic [8:0] a, output logic [7:0] v);
        read_n(a, 1); v = rxb[2];
    endtask

    initial begin
        for (int i = 0; i < 512; i++) shadow[i] = 8'hFF;
        ticks(4); rst_n = 1'b1; ticks(4);

        // R1 reset state
        rdsr(s); check("R1 status", s, 8'h00);
        rd1(9'h000, s); check("R1 mem 000", s, 8'hFF);
        rd1(9'h1AB, s); check("R1 mem 1AB", s, 8'hFF);

        // R2 latch set/clear
        cmd1(8'h06); rdsr(s); check("R2 wren", s, 8'h02);
        cmd1(8'h04); rdsr(s); check("R2 wrdi", s, 8'h00);

        // R3 write without latch
        txb[2] = 8'hAA; write_n(9'h010, 1);
        rdsr(s); check("R3 no busy", s, 8'h00);
        rd1(9'h010, s); check("R3 mem", s, 8'hFF);

        // R5 page wrap, R6 busy, R7 latch clear
        cmd1(8'h06);
        txb[2] = 8'h11; txb[3] = 8'h22; txb[4] = 8'h33; txb[5] = 8'h44;
        write_n(9'h02E, 4);
        shadow[9'h02E] = 8'h11; shadow[9'h02F] = 8'h22;
        shadow[9'h020] = 8'h33; shadow[9'h021] = 8'h44;
        rdsr(s); check("R6 busy status", s, 8'h03);
        rd1(9'h02E, s); check("R6 read while busy", s, 8'h00);
        cmd1(8'h06);
        wait_idle();
        rdsr(s); check("R7 latch cleared", s, 8'h00);
        rd1(9'h02E, s); check("R5 02E", s, 8'h11);
        rd1(9'h02F, s); check("R5 02F", s, 8'h22);
        rd1(9'h020, s); check("R5 020 wrap", s, 8'h33);
        rd1(9'h021, s); check("R5 021", s, 8'h44);
        rd1(9'h030, s); check("R5 next page", s, 8'hFF);

        // R4 upper-half addressing and sequential wrap
        cmd1(8'h06); txb[2] = 8'hAB; txb[3] = 8'hCD; write_n(9'h1FE, 2); wait_idle();
        cmd1(8'h06); txb[2] = 8'h5A; write_n(9'h000, 1); wait_idle();
        shadow[9'h1FE] = 8'hAB; shadow[9'h1FF] = 8'hCD; shadow[9'h000] = 8'h5A;
        read_n(9'h1FE, 3);
        check("R4 seq 1FE", rxb[2], 8'hAB);
        check("R4 seq 1FF", rxb[3], 8'hCD);
        check("R4 seq wrap 000", rxb[4], 8'h5A);
        rd1(9'h0FE, s); check("R4 bit8 select", s, 8'hFF);

        // R8 protection table
        for (int v = 0; v < 8; v++) begin
            logic [1:0] bp; logic [8:0] a; logic [7:0] d; logic w;
            {bp, a, d, w} = PROT_VEC[v];
            cmd1(8'h06); wrsr({4'b0, bp, 2'b00}); wait_idle();
            rdsr(s); check("R8 bp set", s, {4'b0, bp, 2'b00});
            cmd1(8'h06); txb[2] = d; write_n(a, 1); wait_idle();
            if (w) shadow[a] = d;
            rd1(a, s); check("R8 protect", s, shadow[a]);
        end
        cmd1(8'h04);

        // R9 write-protect pin
        wp_n = 1'b0;
        cmd1(8'h06); wrsr(8'h0C); wait_idle();
        rdsr(s); check("R9 status write blocked", s, 8'h02);
        txb[2] = 8'h77; write_n(9'h050, 1); wait_idle();
        rd1(9'h050, s); check("R9 data write blocked", s, 8'hFF);
        wp_n = 1'b1; cmd1(8'h04);

        // R10 repeated status bytes
        cmd1(8'h06);
        txb[0] = 8'h05; txb[1] = 8'h00; txb[2] = 8'h00; frame(3);
        check("R10 status byte 1", rxb[1], 8'h02);
        check("R10 status byte 2", rxb[2], 8'h02);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule